// File: doc/BRIEF.md
# Self-Programming Command Arming Register

This block is the CPU-visible control register that arms flash self-programming commands. Software writes a five-bit command code into the register. A valid code opens a short acceptance window. A store-program-memory instruction strobe that arrives inside this window becomes exactly one command toward a flash controller. The command is one of five: a word store into the temporary page buffer, a page erase, a page write, a lock-bit set, or a read-while-write section re-enable.

The window lasts four cycles. When it runs out with no strobe, the register clears itself. A store, a lock set and a re-enable complete as soon as they are issued, and the register clears at that point. An erase or a page write keeps the enable bit, and its own command bit, set until the flash controller reports completion by dropping its busy signal. If the erase or write targets a page at or above the parameterised start of the non-read-while-write section, the CPU stall output is held for the whole operation.

Top module: `spm_cmd_ctrl`

## Requirements
- R1: After reset, the register reads zero, every command pulse is low, the address, page and data outputs are zero, and cpu_stall is low.
- R2: Only these low-five-bit codes are accepted: 00001 (store), 00011 (erase), 00101 (page write), 01001 (lock set) and 10001 (re-enable). The bits are assigned as bit 0 enable, bit 1 erase, bit 2 page write, bit 3 lock set and bit 4 re-enable. A write of any other low-five-bit value leaves the register unchanged. Bits 7..5 of a write are discarded and always read as zero.
- R3: A strobe is acted on in any of the four cycles that follow a valid register write. If no strobe arrives in those four cycles, the register reads zero from the fifth cycle on, and a strobe in the fifth cycle does nothing.
- R4: A strobe under code 00001 produces a one-cycle cmd_buf_store pulse in the cycle after the strobe. In that same cycle, cmd_word_addr equals ptr_addr shifted right by one, and cmd_data equals data_word. The register then reads zero. At most one command pulse is high in any cycle.
- R5: A strobe under code 00011 or 00101 produces a one-cycle erase or page-write pulse in the cycle after the strobe. In that cycle, cmd_page equals ptr_addr shifted right by PAGE_BYTES_LOG2, and cmd_data is zero, so the data word is ignored.
- R6: During an erase or page write, the register keeps its code until the first cycle in which flash_busy is low after having been high. At the clock edge that ends that cycle, the register clears.
- R7: A register write made while an erase or page write is in progress is ignored.
- R8: A valid register write made while the window is open reloads the window to a full four cycles.
- R9: cpu_stall is high from the cycle after the strobe until the operation completes. This applies only when the erase or write page is at or above NRWW_FIRST_PAGE. For a page below that boundary, cpu_stall stays low.
- R10: A strobe under code 01001 or 10001 produces a one-cycle cmd_lock_set or cmd_rww_enable pulse, and the register then reads zero.
- R11: A strobe made while no window is open produces no command pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read data |
| spm_strobe | input | 1 | Store-program-memory instruction strobe |
| ptr_addr | input | ADDR_W | Byte address pointer |
| data_word | input | DATA_W | Data word to store |
| flash_busy | input | 1 | Flash controller busy, falling edge marks completion |
| cmd_buf_store | output | 1 | Page buffer word store pulse |
| cmd_page_erase | output | 1 | Page erase pulse |
| cmd_page_write | output | 1 | Page write pulse |
| cmd_lock_set | output | 1 | Lock-bit set pulse |
| cmd_rww_enable | output | 1 | Read-while-write re-enable pulse |
| cmd_word_addr | output | ADDR_W | Word address for the command |
| cmd_page | output | ADDR_W-PAGE_BYTES_LOG2 | Page number for the command |
| cmd_data | output | DATA_W | Data for a buffer store, zero otherwise |
| cpu_stall | output | 1 | CPU stall during a non-read-while-write operation |

## Verification
The bench drives each of the five valid codes, then several invalid codes with the enable bit set. This separates correct code screening from a plain enable-bit test. Strobes are placed in the fourth window cycle and in the fifth, which pins the window length to exactly four. A rewrite made in the last window cycle shows whether the window is reloaded or only left running. An erase below the section boundary is compared against a page write above it, which shows that the stall follows the page and not the command type. A register write made while busy checks that the in-progress command is held.

// File: rtl/spm_pkg.sv
// Package: command codes, operation type and the code screening function
// shared by the self-programming control register and its checker.
package spm_pkg;

    localparam logic [4:0] CODE_STORE = 5'b00001;
    localparam logic [4:0] CODE_ERASE = 5'b00011;
    localparam logic [4:0] CODE_WRITE = 5'b00101;
    localparam logic [4:0] CODE_LOCK  = 5'b01001;
    localparam logic [4:0] CODE_RWW   = 5'b10001;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_STORE,
        OP_ERASE,
        OP_WRITE,
        OP_LOCK,
        OP_RWW
    } spm_op_e;

    // Returns the operation a five-bit code selects, OP_NONE if invalid.
    function automatic spm_op_e code_to_op(input logic [4:0] code);
        case (code)
            CODE_STORE: return OP_STORE;
            CODE_ERASE: return OP_ERASE;
            CODE_WRITE: return OP_WRITE;
            CODE_LOCK:  return OP_LOCK;
            CODE_RWW:   return OP_RWW;
            default:    return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spm_code_decode.sv
// Module: spm_code_decode
// Classifies a five-bit command code. Purely combinational.
// Assumes: the caller supplies only the low five register bits.
module spm_code_decode
    import spm_pkg::*;
(
    input  logic [4:0] code,
    output logic       valid,
    output spm_op_e    op,
    output logic       long_op
);

    // Map the code to an operation and flag operations that wait on flash.
    always_comb begin
        op      = code_to_op(code);
        valid   = (op != OP_NONE);
        long_op = (op == OP_ERASE) || (op == OP_WRITE);
    end

endmodule

// File: rtl/spm_arm_window.sv
// Module: spm_arm_window
// Counts down the acceptance window that follows a valid register write.
// Assumes: load and cancel are never high in the same cycle.
module spm_arm_window #(
    parameter int WINDOW_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic cancel,
    output logic armed,
    output logic expire
);

    localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Reload on a write, drop on acceptance, otherwise count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(WINDOW_CYCLES);
        end else if (cancel) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Armed while the counter is non-zero. Expire flags the final idle cycle.
    always_comb begin
        armed  = (cnt_q != '0);
        expire = (cnt_q == CNT_W'(1)) && !load && !cancel;
    end

endmodule

// File: rtl/spm_op_tracker.sv
// Module: spm_op_tracker
// Tracks an erase or page write until the flash busy line falls. Holds the
// CPU stall for operations in the non-read-while-write section.
// Assumes: start is only raised while no operation is in progress.
module spm_op_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stall_req,
    input  logic flash_busy,
    output logic op_busy,
    output logic done,
    output logic cpu_stall
);

    logic busy_q;

    // Register the busy line to detect its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= flash_busy;
    end

    // Completion is the busy falling edge during an operation.
    always_comb done = op_busy && busy_q && !flash_busy;

    // Set the operation and stall flags on start, clear them on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_busy   <= 1'b0;
            cpu_stall <= 1'b0;
        end else if (start) begin
            op_busy   <= 1'b1;
            cpu_stall <= stall_req;
        end else if (done) begin
            op_busy   <= 1'b0;
            cpu_stall <= 1'b0;
        end
    end

endmodule

// File: rtl/spm_cmd_ctrl.sv
// Module: spm_cmd_ctrl (top)
// Self-programming command arming register. A valid code write opens a
// window in which one instruction strobe becomes a single registered
// command pulse toward the flash controller.
// Assumes: flash_busy rises after an erase or write pulse and falls once
// when that operation ends. A strobe takes priority over a same-cycle write.
module spm_cmd_ctrl
    import spm_pkg::*;
#(
    parameter int ADDR_W          = 16,
    parameter int DATA_W          = 16,
    parameter int PAGE_BYTES_LOG2 = 8,
    parameter int NRWW_FIRST_PAGE = 224,
    parameter int WINDOW_CYCLES   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr_en,
    input  logic [7:0]                        reg_wr_data,
    output logic [7:0]                        reg_rd_data,
    input  logic                              spm_strobe,
    input  logic [ADDR_W-1:0]                 ptr_addr,
    input  logic [DATA_W-1:0]                 data_word,
    input  logic                              flash_busy,
    output logic                              cmd_buf_store,
    output logic                              cmd_page_erase,
    output logic                              cmd_page_write,
    output logic                              cmd_lock_set,
    output logic                              cmd_rww_enable,
    output logic [ADDR_W-1:0]                 cmd_word_addr,
    output logic [ADDR_W-PAGE_BYTES_LOG2-1:0] cmd_page,
    output logic [DATA_W-1:0]                 cmd_data,
    output logic                              cpu_stall
);

    localparam int PAGE_W = ADDR_W - PAGE_BYTES_LOG2;

    logic [4:0]        ctrl_q;
    logic [4:0]        wr_code;
    logic              wr_valid, wr_long, cur_valid, cur_long;
    spm_op_e           wr_op, cur_op;
    logic              armed, expire, op_busy, done;
    logic              accept, wr_ok, start_long, stall_req;
    logic [PAGE_W-1:0] ptr_page;

    // Extract the code field of a write and the page of the pointer.
    always_comb begin
        wr_code  = 5'(reg_wr_data);
        ptr_page = PAGE_W'(ptr_addr >> PAGE_BYTES_LOG2);
    end

    spm_code_decode u_wr_dec (
        .code    (wr_code),
        .valid   (wr_valid),
        .op      (wr_op),
        .long_op (wr_long)
    );

    spm_code_decode u_cur_dec (
        .code    (ctrl_q),
        .valid   (cur_valid),
        .op      (cur_op),
        .long_op (cur_long)
    );

    // Decide strobe acceptance and whether a write may load the register.
    always_comb begin
        accept     = spm_strobe && armed && cur_valid && !op_busy;
        wr_ok      = reg_wr_en && wr_valid && !op_busy && !accept;
        start_long = accept && cur_long;
        stall_req  = (ptr_page >= PAGE_W'(NRWW_FIRST_PAGE));
    end

    spm_arm_window #(
        .WINDOW_CYCLES (WINDOW_CYCLES)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wr_ok),
        .cancel (accept),
        .armed  (armed),
        .expire (expire)
    );

    spm_op_tracker u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_long),
        .stall_req  (stall_req),
        .flash_busy (flash_busy),
        .op_busy    (op_busy),
        .done       (done),
        .cpu_stall  (cpu_stall)
    );

    // Control bits: clear on completion or timeout, load on a valid write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (done) begin
            ctrl_q <= '0;
        end else if (accept) begin
            ctrl_q <= cur_long ? ctrl_q : 5'b0;
        end else if (wr_ok) begin
            ctrl_q <= wr_code;
        end else if (expire) begin
            ctrl_q <= '0;
        end
    end

    // Command outputs: registered one-cycle pulses with address, page, data.
    always_ff @(posedge clk) begin
        if (!rst_n || !accept) begin
            cmd_buf_store  <= 1'b0;
            cmd_page_erase <= 1'b0;
            cmd_page_write <= 1'b0;
            cmd_lock_set   <= 1'b0;
            cmd_rww_enable <= 1'b0;
            cmd_word_addr  <= '0;
            cmd_page       <= '0;
            cmd_data       <= '0;
        end else begin
            cmd_buf_store  <= (cur_op == OP_STORE);
            cmd_page_erase <= (cur_op == OP_ERASE);
            cmd_page_write <= (cur_op == OP_WRITE);
            cmd_lock_set   <= (cur_op == OP_LOCK);
            cmd_rww_enable <= (cur_op == OP_RWW);
            cmd_word_addr  <= ptr_addr >> 1;
            cmd_page       <= ptr_page;
            cmd_data       <= (cur_op == OP_STORE) ? data_word : '0;
        end
    end

    // Read port: the five control bits, upper bits zero.
    always_comb reg_rd_data = {3'b000, ctrl_q};

endmodule

// File: rtl/spm_cmd_ctrl_chk.sv
// Module: spm_cmd_ctrl_chk
// Checker of port-level properties of spm_cmd_ctrl, bound to it below.
// Assumes: synchronous active-low reset as in the design.
module spm_cmd_ctrl_chk
    import spm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_rd_data,
    input logic       cmd_buf_store,
    input logic       cmd_page_erase,
    input logic       cmd_page_write,
    input logic       cmd_lock_set,
    input logic       cmd_rww_enable,
    input logic       cpu_stall
);

    logic [4:0] pulses;
    always_comb pulses = {cmd_buf_store, cmd_page_erase, cmd_page_write,
                          cmd_lock_set, cmd_rww_enable};

    assert_one_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses));

    assert_store_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_buf_store |-> (reg_rd_data == 8'h00));

    assert_erase_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_page_erase |-> (reg_rd_data == 8'h03));

    assert_write_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_page_write |-> (reg_rd_data == 8'h05));

    assert_lock_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lock_set || cmd_rww_enable) |-> (reg_rd_data == 8'h00));

    assert_stall_in_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> reg_rd_data[0]);

    assert_valid_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data != 8'h00) |-> (code_to_op(reg_rd_data[4:0]) != OP_NONE));

    assert_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pulses != 5'b0) |-> $past(reg_rd_data[0]));

endmodule

bind spm_cmd_ctrl spm_cmd_ctrl_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_rd_data    (reg_rd_data),
    .cmd_buf_store  (cmd_buf_store),
    .cmd_page_erase (cmd_page_erase),
    .cmd_page_write (cmd_page_write),
    .cmd_lock_set   (cmd_lock_set),
    .cmd_rww_enable (cmd_rww_enable),
    .cpu_stall      (cpu_stall)
);

// File: tb/spm_cmd_ctrl_tb.sv
// Bench for spm_cmd_ctrl: a behavioural reference model advanced every clock
// and compared at each falling edge, plus directed scenario checks.
module spm_cmd_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 16;
    localparam int PG_LOG2    = 8;
    localparam int NRWW_PG    = 224;
    localparam int WIN        = 4;
    localparam int MAX_CYC    = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [7:0]        reg_wr_data = '0;
    logic [7:0]        reg_rd_data;
    logic              spm_strobe = 1'b0;
    logic [ADDR_W-1:0] ptr_addr = '0;
    logic [DATA_W-1:0] data_word = '0;
    logic              flash_busy = 1'b0;
    logic              cmd_buf_store, cmd_page_erase, cmd_page_write;
    logic              cmd_lock_set, cmd_rww_enable, cpu_stall;
    logic [ADDR_W-1:0] cmd_word_addr;
    logic [ADDR_W-PG_LOG2-1:0] cmd_page;
    logic [DATA_W-1:0] cmd_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit compare_on = 1'b0;

    // Reference model state
    int m_ctrl, m_cnt, m_op, m_bq, m_stall;
    int e_st, e_er, e_wr, e_lk, e_rw, e_word, e_page, e_data;
    // Pulse tallies seen at the ports
    int n_st, n_er, n_wr, n_lk, n_rw, n_stall;

    spm_cmd_ctrl #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .PAGE_BYTES_LOG2 (PG_LOG2),
        .NRWW_FIRST_PAGE (NRWW_PG), .WINDOW_CYCLES (WIN)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .reg_wr_en (reg_wr_en),
        .reg_wr_data (reg_wr_data), .reg_rd_data (reg_rd_data),
        .spm_strobe (spm_strobe), .ptr_addr (ptr_addr), .data_word (data_word),
        .flash_busy (flash_busy), .cmd_buf_store (cmd_buf_store),
        .cmd_page_erase (cmd_page_erase), .cmd_page_write (cmd_page_write),
        .cmd_lock_set (cmd_lock_set), .cmd_rww_enable (cmd_rww_enable),
        .cmd_word_addr (cmd_word_addr), .cmd_page (cmd_page),
        .cmd_data (cmd_data), .cpu_stall (cpu_stall)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic bit good_code(input int c);
        return (c == 1) || (c == 3) || (c == 5) || (c == 9) || (c == 17);
    endfunction

    // Reference model: advances with each rising edge from the sampled inputs.
    always @(posedge clk) begin
        cyc++;
        e_st = 0; e_er = 0; e_wr = 0; e_lk = 0; e_rw = 0;
        e_word = 0; e_page = 0; e_data = 0;
        if (!rst_n) begin
            m_ctrl = 0; m_cnt = 0; m_op = 0; m_bq = 0; m_stall = 0;
        end else begin
            if (m_op != 0) begin
                if (m_bq != 0 && !flash_busy) begin
                    m_op = 0; m_ctrl = 0; m_stall = 0;
                end
            end else if (m_cnt > 0 && spm_strobe) begin
                e_word = int'(ptr_addr) / 2;
                e_page = int'(ptr_addr) / (1 << PG_LOG2);
                m_cnt = 0;
                case (m_ctrl)
                    1:  begin e_st = 1; e_data = int'(data_word); m_ctrl = 0; end
                    3:  begin e_er = 1; m_op = 1; m_stall = (e_page >= NRWW_PG); end
                    5:  begin e_wr = 1; m_op = 1; m_stall = (e_page >= NRWW_PG); end
                    9:  begin e_lk = 1; m_ctrl = 0; end
                    default: begin e_rw = 1; m_ctrl = 0; end
                endcase
            end else if (reg_wr_en && good_code(int'(reg_wr_data) % 32)) begin
                m_ctrl = int'(reg_wr_data) % 32;
                m_cnt = WIN;
            end else if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) m_ctrl = 0;
            end
            m_bq = flash_busy;
        end
    end

    // Compare every cycle at the falling edge and tally pulses seen.
    always @(negedge clk) begin
        if (compare_on) begin
            chk("R2 register", int'(reg_rd_data), m_ctrl);
            chk("R4 store pulse", int'(cmd_buf_store), e_st);
            chk("R5 erase pulse", int'(cmd_page_erase), e_er);
            chk("R5 write pulse", int'(cmd_page_write), e_wr);
            chk("R10 lock pulse", int'(cmd_lock_set), e_lk);
            chk("R10 rww pulse", int'(cmd_rww_enable), e_rw);
            chk("R4 word addr", int'(cmd_word_addr), e_word);
            chk("R5 page", int'(cmd_page), e_page);
            chk("R4 data", int'(cmd_data), e_data);
            chk("R9 stall", int'(cpu_stall), m_stall);
            n_st += int'(cmd_buf_store); n_er += int'(cmd_page_erase);
            n_wr += int'(cmd_page_write); n_lk += int'(cmd_lock_set);
            n_rw += int'(cmd_rww_enable); n_stall += int'(cpu_stall);
        end
    end

    task automatic clear_tally();
        n_st = 0; n_er = 0; n_wr = 0; n_lk = 0; n_rw = 0; n_stall = 0;
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr_en = 1'b1; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_data = '0;
    endtask

    task automatic strobe(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        spm_strobe = 1'b1; ptr_addr = a; data_word = d;
        @(negedge clk);
        spm_strobe = 1'b0; ptr_addr = '0; data_word = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic flash_cycle(input int len);
        idle(2);
        flash_busy = 1'b1;
        idle(len);
        flash_busy = 1'b0;
        idle(2);
    endtask

    // Watchdog: an overrun counts as a failed check.
    initial begin
        wait (cyc > MAX_CYC);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, MAX_CYC);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_tally();
        idle(3);
        // R1: reset state
        chk("R1 rd", int'(reg_rd_data), 0);
        chk("R1 pulses", int'({cmd_buf_store, cmd_page_erase, cmd_page_write,
                               cmd_lock_set, cmd_rww_enable}), 0);
        chk("R1 outputs", int'(cmd_word_addr) + int'(cmd_page) + int'(cmd_data), 0);
        chk("R1 stall", int'(cpu_stall), 0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        idle(1);

        // R2: invalid codes ignored, upper bits dropped
        wr(8'h07); chk("R2 invalid 00111", int'(reg_rd_data), 0);
        wr(8'h1F); chk("R2 invalid 11111", int'(reg_rd_data), 0);
        wr(8'hE1); chk("R2 upper bits", int'(reg_rd_data), 1);
        wr(8'h0D); chk("R2 invalid in window", int'(reg_rd_data), 1);
        idle(5);

        // R3/R4: strobe in the fourth window cycle is accepted
        clear_tally();
        wr(8'h01); idle(3);
        strobe(16'h1235, 16'hBEEF);
        idle(1);
        chk("R3 fourth cycle accepted", n_st, 1);
        chk("R4 cleared", int'(reg_rd_data), 0);

        // R3/R11: expiry after four cycles; fifth-cycle strobe ignored
        clear_tally();
        wr(8'h01); idle(4);
        chk("R3 expired", int'(reg_rd_data), 0);
        strobe(16'h0040, 16'h1111);
        idle(2);
        chk("R11 no pulse", n_st + n_er + n_wr + n_lk + n_rw, 0);

        // R8: rewrite in last window cycle reloads
        clear_tally();
        wr(8'h01); idle(3); wr(8'h01); idle(3);
        strobe(16'h0102, 16'h5A5A);
        idle(1);
        chk("R8 reload accepted", n_st, 1);

        // R5/R6/R7: erase below boundary, write during busy ignored
        clear_tally();
        wr(8'h03);
        strobe(16'h0304, 16'hFFFF);
        idle(2);
        flash_busy = 1'b1;
        wr(8'h01);
        chk("R7 write ignored", int'(reg_rd_data), 3);
        idle(3);
        chk("R6 held while busy", int'(reg_rd_data), 3);
        flash_busy = 1'b0;
        idle(2);
        chk("R6 cleared at completion", int'(reg_rd_data), 0);
        chk("R5 erase issued", n_er, 1);
        chk("R9 no stall below boundary", n_stall, 0);

        // R9: page write above boundary stalls the whole operation
        clear_tally();
        wr(8'h05);
        strobe(16'hF010, 16'h0000);
        flash_cycle(6);
        chk("R5 write issued", n_wr, 1);
        chk("R9 stall cycles", n_stall, 9);
        chk("R9 stall released", int'(cpu_stall), 0);

        // R10: lock set and re-enable
        clear_tally();
        wr(8'h09); idle(1); strobe(16'h0001, 16'h00AA); idle(1);
        wr(8'h11); strobe(16'h0002, 16'h0000); idle(1);
        chk("R10 lock", n_lk, 1);
        chk("R10 rww", n_rw, 1);
        chk("R10 cleared", int'(reg_rd_data), 0);

        // R11: strobe with nothing written
        clear_tally();
        strobe(16'h0100, 16'h1234); idle(2);
        chk("R11 idle strobe", n_st + n_er + n_wr + n_lk + n_rw, 0);

        compare_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule